// File: doc/BRIEF.md
# Hidden DAC Colour-Mode Register Guard

This block snoops the legacy VGA I/O port accesses that reach the display controller and owns three small registers: the palette pixel mask, a hidden colour-mode register, and an extended-mode register. The hidden register has no address of its own. Software reaches it by reading the pixel-mask port a fixed number of times in a row. The next write to that port then lands in the hidden register instead of the mask. A read of the DAC write-index port, or any other access, breaks the sequence and starts the count again.

The extended-mode register sits behind the sequencer index/data port pair. The block combines it with the hidden register into a pixel-format output and a linear-framebuffer enable, which the video pipeline uses downstream. Reads are answered in the same cycle on `io_rdata`, and register updates take effect at the clock edge that ends the access.

Top module: `dac_mode_guard`

## Requirements
- R1: After a synchronous reset, the pixel mask is 0xFF, the hidden register and the extended-mode register are 0x00, the unlock count is zero, `fmt_o` is 0 and `lfb_en_o` is 0.
- R2: While the guard is locked, a write to port 0x3C6 updates the pixel mask. The new value appears on `pix_mask_o` after that clock edge and is returned by a locked read of 0x3C6.
- R3: After four consecutive reads of 0x3C6, the next write to 0x3C6 is stored in the hidden register, and the pixel mask keeps its value.
- R4: A read of 0x3C6 returns the pixel mask while fewer than four consecutive reads have been counted. Once four have been counted, every further read of 0x3C6 returns the hidden register.
- R5: A write that goes to the hidden register clears the count, so the very next write to 0x3C6 updates the pixel mask.
- R6: Any access other than a read of 0x3C6 resets the count to zero. This includes a read or write of 0x3C8, any access to the sequencer ports 0x3C4 and 0x3C5, and any access to an unrelated port.
- R7: A write to 0x3C6 made before the count reaches four goes to the pixel mask and resets the count to zero.
- R8: A write to 0x3C4 sets the sequencer index, and a read of 0x3C4 returns it. With index 7, a write to 0x3C5 loads the extended-mode register, and a read of 0x3C5 returns it with bits 2:1 read as 0. With any other index, writes to 0x3C5 are ignored and reads of 0x3C5 return 0.
- R9: `fmt_o` encodes the pixel format. It is 0 (8-bit indexed) unless the hidden register holds 0xC5 and extended-mode bit 0 is 1. In that case it is 2 (32-bit direct) when extended-mode bit 3 is 1, and 1 (24-bit direct) when bit 3 is 0.
- R10: `lfb_en_o` is 1 exactly when any of extended-mode bits 7:4 is 1.
- R11: The unlock count never goes above four. A read of a port other than 0x3C4, 0x3C5 or 0x3C6, and any cycle without a read, gives 0 on `io_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_valid | input | 1 | An I/O access is presented this cycle |
| io_write | input | 1 | 1 for a write, 0 for a read |
| io_addr | input | 16 | I/O port address |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the same cycle as a read |
| pix_mask_o | output | 8 | Current palette pixel mask |
| fmt_o | output | 2 | Pixel format: 0 indexed 8, 1 direct 24, 2 direct 32 |
| lfb_en_o | output | 1 | Linear framebuffer enable |

## Verification
The assertions check several rules on every cycle. The unlock count stays at or below four and, when it moves, either steps up by one or drops to zero. The hidden register changes only in the cycle after a redirected write, and the mask holds steady through such a write. The extended-mode register changes only while index 7 is selected. A non-indexed format never appears without extended modes enabled. Other properties depend on whole access sequences and only the bench's scenarios can show them. These are where the fourth read falls, the relock after a hidden write, how each kind of interrupting access clears the count, and the full format and framebuffer decode across all 256 extended-mode values.

// File: rtl/dac_guard_pkg.sv
package dac_guard_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] PORT_SEQ_IDX  = 16'h03C4;
    localparam logic [ADDR_W-1:0] PORT_SEQ_DAT  = 16'h03C5;
    localparam logic [ADDR_W-1:0] PORT_PIX_MASK = 16'h03C6;
    localparam logic [ADDR_W-1:0] PORT_DAC_WIDX = 16'h03C8;

    localparam logic [DATA_W-1:0] EXT_MODE_IDX   = 8'h07;
    localparam logic [DATA_W-1:0] TRUECOLOR_CODE = 8'hC5;
    localparam logic [DATA_W-1:0] MASK_RESET     = 8'hFF;

    typedef enum logic [1:0] {
        PIX_INDEXED8 = 2'd0,
        PIX_RGB24    = 2'd1,
        PIX_RGB32    = 2'd2
    } pix_fmt_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } io_req_t;

    // Only the implemented fields of the extended-mode byte are stored.
    typedef struct packed {
        logic [3:0] lfb;
        logic       bpp32;
        logic       ext_en;
    } ext_mode_t;

    function automatic ext_mode_t ext_from_byte(input logic [DATA_W-1:0] b);
        ext_mode_t e;
        e.lfb    = b[7:4];
        e.bpp32  = b[3];
        e.ext_en = b[0];
        return e;
    endfunction

    function automatic logic [DATA_W-1:0] ext_to_byte(input ext_mode_t e);
        return {e.lfb, e.bpp32, 2'b00, e.ext_en};
    endfunction

    function automatic pix_fmt_e decode_fmt(input ext_mode_t e, input logic [DATA_W-1:0] hid);
        if (e.ext_en && hid == TRUECOLOR_CODE)
            return e.bpp32 ? PIX_RGB32 : PIX_RGB24;
        return PIX_INDEXED8;
    endfunction

endpackage

// File: rtl/dac_unlock_seq.sv
module dac_unlock_seq
    import dac_guard_pkg::*;
#(
    parameter int UNLOCK_READS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic acc_valid,
    input  logic acc_write,
    input  logic acc_is_mask,
    output logic unlocked,
    output logic hid_we,
    output logic mask_we
);
    localparam int CW = $clog2(UNLOCK_READS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(UNLOCK_READS);

    logic [CW-1:0] cnt;
    logic mask_rd, mask_wr;

    assign mask_rd  = acc_valid && !acc_write && acc_is_mask;
    assign mask_wr  = acc_valid &&  acc_write && acc_is_mask;
    assign unlocked = (cnt == LIMIT);
    assign hid_we   = mask_wr &&  unlocked;
    assign mask_we  = mask_wr && !unlocked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (acc_valid) begin
            if (mask_rd) begin
                if (!unlocked) cnt <= cnt + CW'(1);
            end else begin
                cnt <= '0;
            end
        end
    end

    assert_cnt_bound_R11: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CW'(1)));

    assert_relock_R5: assert property (@(posedge clk) disable iff (rst)
        hid_we |=> !unlocked);

endmodule

// File: rtl/dac_mode_regs.sv
module dac_mode_regs
    import dac_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  io_req_t           req,
    input  logic              hid_we,
    input  logic              mask_we,
    output logic [DATA_W-1:0] pix_mask,
    output logic [DATA_W-1:0] hidden,
    output logic [DATA_W-1:0] seq_idx,
    output ext_mode_t         ext_mode
);
    logic idx_we, ext_we;

    assign idx_we = req.valid && req.write && (req.addr == PORT_SEQ_IDX);
    assign ext_we = req.valid && req.write && (req.addr == PORT_SEQ_DAT)
                    && (seq_idx == EXT_MODE_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_mask <= MASK_RESET;
            hidden   <= '0;
            seq_idx  <= '0;
            ext_mode <= '0;
        end else begin
            if (mask_we) pix_mask <= req.data;
            if (hid_we)  hidden   <= req.data;
            if (idx_we)  seq_idx  <= req.data;
            if (ext_we)  ext_mode <= ext_from_byte(req.data);
        end
    end

    assert_hidden_guard_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(hidden) |-> $past(hid_we));

    assert_mask_keep_R3: assert property (@(posedge clk) disable iff (rst)
        hid_we |=> $stable(pix_mask));

    assert_ext_index_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ext_mode) |-> ($past(seq_idx) == EXT_MODE_IDX));

endmodule

// File: rtl/dac_fmt_decode.sv
module dac_fmt_decode
    import dac_guard_pkg::*;
(
    input  ext_mode_t         ext_mode,
    input  logic [DATA_W-1:0] hidden,
    output pix_fmt_e          fmt,
    output logic              lfb_en
);
    always_comb begin
        fmt    = decode_fmt(ext_mode, hidden);
        lfb_en = |ext_mode.lfb;
    end
endmodule

// File: rtl/dac_mode_guard.sv
module dac_mode_guard
    import dac_guard_pkg::*;
#(
    parameter int UNLOCK_READS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        io_valid,
    input  logic        io_write,
    input  logic [15:0] io_addr,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic [7:0]  pix_mask_o,
    output logic [1:0]  fmt_o,
    output logic        lfb_en_o
);
    io_req_t           req;
    logic              unlocked, hid_we, mask_we;
    logic [DATA_W-1:0] hidden, seq_idx, pix_mask;
    ext_mode_t         ext_mode;
    pix_fmt_e          fmt;

    assign req = '{valid: io_valid, write: io_write, addr: io_addr, data: io_wdata};

    dac_unlock_seq #(.UNLOCK_READS(UNLOCK_READS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (req.valid),
        .acc_write  (req.write),
        .acc_is_mask(req.addr == PORT_PIX_MASK),
        .unlocked   (unlocked),
        .hid_we     (hid_we),
        .mask_we    (mask_we)
    );

    dac_mode_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .hid_we  (hid_we),
        .mask_we (mask_we),
        .pix_mask(pix_mask),
        .hidden  (hidden),
        .seq_idx (seq_idx),
        .ext_mode(ext_mode)
    );

    dac_fmt_decode u_dec (
        .ext_mode(ext_mode),
        .hidden  (hidden),
        .fmt     (fmt),
        .lfb_en  (lfb_en_o)
    );

    always_comb begin
        io_rdata = '0;
        if (req.valid && !req.write) begin
            unique case (req.addr)
                PORT_PIX_MASK: io_rdata = unlocked ? hidden : pix_mask;
                PORT_SEQ_IDX:  io_rdata = seq_idx;
                PORT_SEQ_DAT:  io_rdata = (seq_idx == EXT_MODE_IDX) ? ext_to_byte(ext_mode) : '0;
                default:       io_rdata = '0;
            endcase
        end
    end

    assign pix_mask_o = pix_mask;
    assign fmt_o      = fmt;

    assert_fmt_needs_ext_R9: assert property (@(posedge clk) disable iff (rst)
        (fmt != PIX_INDEXED8) |-> ext_mode.ext_en);

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (rst)
        !io_valid |-> (io_rdata == '0));

    assert_locked_read_R4: assert property (@(posedge clk) disable iff (rst)
        (io_valid && !io_write && io_addr == PORT_PIX_MASK && !unlocked) |-> (io_rdata == pix_mask_o));

endmodule

// File: tb/dac_mode_guard_bench.sv
`timescale 1ns/1ps
module dac_mode_guard_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       io_valid = 1'b0;
    logic       io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic [7:0] pix_mask_o;
    logic [1:0] fmt_o;
    logic       lfb_en_o;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_mask;
    logic [7:0] m_hid;

    always #2.5 clk = ~clk;

    dac_mode_guard u_dac_mode_guard (
        .clk(clk), .rst(rst), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .pix_mask_o(pix_mask_o), .fmt_o(fmt_o), .lfb_en_o(lfb_en_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input logic w, input logic [15:0] a, input logic [7:0] d, output logic [7:0] r);
        @(negedge clk);
        io_valid = 1'b1; io_write = w; io_addr = a; io_wdata = d;
        #1 r = io_rdata;
        @(posedge clk);
        #1 io_valid = 1'b0; io_write = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] r;
        bus(1'b1, a, d, r);
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] r);
        bus(1'b0, a, 8'h00, r);
    endtask

    task automatic set_hidden(input logic [7:0] v);
        logic [7:0] r;
        rd(16'h03C8, r);
        for (int i = 0; i < 4; i++) rd(16'h03C6, r);
        wr(16'h03C6, v);
        m_hid = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", pix_mask_o, 8'hFF);
        chk("R1 fmt", {6'd0, fmt_o}, 8'h00);
        chk("R1 lfb", {7'd0, lfb_en_o}, 8'h00);
        chk("R11 idle rdata", io_rdata, 8'h00);
        wr(16'h03C4, 8'h07);
        rd(16'h03C5, r); chk("R1 ext", r, 8'h00);
        rd(16'h03C6, r); chk("R1 mask read", r, 8'hFF);
        m_mask = 8'hFF; m_hid = 8'h00;
        // hidden reads back 0 after reset
        rd(16'h03C8, r); chk("R11 3C8 read", r, 8'h00);
        for (int i = 0; i < 4; i++) rd(16'h03C6, r);
        rd(16'h03C6, r); chk("R1 hidden", r, 8'h00);

        // R2 locked mask write
        rd(16'h03C8, r);
        wr(16'h03C6, 8'h5A); m_mask = 8'h5A;
        chk("R2 mask port", pix_mask_o, 8'h5A);
        rd(16'h03C6, r); chk("R2 mask read", r, 8'h5A);

        // R3 R4 R5 R7 R11: sweep the number of reads before a write
        for (int k = 0; k <= 6; k++) begin
            logic [7:0] v;
            v = 8'h10 + 8'(k) * 8'h11;
            rd(16'h03C8, r);
            for (int j = 0; j < k; j++) begin
                rd(16'h03C6, r);
                chk((j < 4) ? "R4 locked read" : "R4 unlocked read", r, (j < 4) ? m_mask : m_hid);
            end
            wr(16'h03C6, v);
            if (k >= 4) begin
                m_hid = v;
                chk("R3 mask kept", pix_mask_o, m_mask);
                wr(16'h03C6, ~v); m_mask = ~v;
                chk("R5 relock to mask", pix_mask_o, m_mask);
                rd(16'h03C8, r);
                for (int j = 0; j < 4; j++) rd(16'h03C6, r);
                rd(16'h03C6, r); chk("R3 hidden value", r, m_hid);
                rd(16'h03C6, r); chk("R11 saturated read", r, m_hid);
            end else begin
                m_mask = v;
                chk("R7 early write to mask", pix_mask_o, v);
            end
        end

        // R7: an early write resets the count
        rd(16'h03C8, r);
        for (int j = 0; j < 3; j++) rd(16'h03C6, r);
        wr(16'h03C6, 8'hA1); m_mask = 8'hA1;
        for (int j = 0; j < 3; j++) rd(16'h03C6, r);
        wr(16'h03C6, 8'hB2); m_mask = 8'hB2;
        chk("R7 count cleared by write", pix_mask_o, 8'hB2);

        // R6: every kind of interrupting access at every position
        for (int t = 0; t < 6; t++) begin
            for (int p = 1; p <= 3; p++) begin
                logic [7:0] w;
                w = 8'h40 + 8'(t * 4 + p);
                rd(16'h03C8, r);
                for (int j = 0; j < p; j++) rd(16'h03C6, r);
                case (t)
                    0: rd(16'h03C8, r);
                    1: wr(16'h03C8, 8'h00);
                    2: wr(16'h03C4, 8'h07);
                    3: rd(16'h03C5, r);
                    4: rd(16'h03C7, r);
                    default: wr(16'h03D4, 8'h11);
                endcase
                for (int j = 0; j < 4 - p; j++) rd(16'h03C6, r);
                wr(16'h03C6, w); m_mask = w;
                chk("R6 interrupted sequence", pix_mask_o, w);
            end
        end
        rd(16'h03C8, r);
        for (int j = 0; j < 4; j++) rd(16'h03C6, r);
        rd(16'h03C6, r); chk("R6 hidden untouched", r, m_hid);
        rd(16'h03D4, r); chk("R11 unmapped read", r, 8'h00);

        // R8 other index ignored
        wr(16'h03C4, 8'h07); wr(16'h03C5, 8'h39);
        wr(16'h03C4, 8'h06);
        rd(16'h03C4, r); chk("R8 index read", r, 8'h06);
        wr(16'h03C5, 8'hF6);
        rd(16'h03C5, r); chk("R8 other index reads 0", r, 8'h00);
        wr(16'h03C4, 8'h07);
        rd(16'h03C5, r); chk("R8 ext untouched", r, 8'h39);

        // R8 R9 R10: full sweep of the extended-mode byte
        for (int h = 0; h < 3; h++) begin
            set_hidden((h == 0) ? 8'hC5 : (h == 1) ? 8'h00 : 8'hC4);
            wr(16'h03C4, 8'h07);
            for (int e = 0; e < 256; e++) begin
                logic [7:0] eb;
                logic [1:0] ef;
                eb = 8'(e);
                wr(16'h03C5, eb);
                rd(16'h03C5, r);
                chk("R8 ext readback", r, eb & 8'hF9);
                ef = (m_hid == 8'hC5 && eb[0]) ? (eb[3] ? 2'd2 : 2'd1) : 2'd0;
                chk("R9 fmt", {6'd0, fmt_o}, {6'd0, ef});
                chk("R10 lfb", {7'd0, lfb_en_o}, {7'd0, (eb[7:4] != 4'd0)});
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule